// File: doc/BRIEF.md
# Two-Stage Burst Stream Writer

This block accepts a stream of narrow items, marked at its end by an end-of-stream beat, and stores them in memory through a simple burst-write master port. The port has an address phase and a data phase. The address phase carries a start address and a burst length in lines, held under a request/acknowledge handshake. The data phase carries one line per beat under a valid/ready handshake, with a last flag on the final beat.

The block has two concurrent stages. The packer gathers items into wide lines, least significant slot first. It places each finished line in a line queue that holds two bursts' worth of lines. Each time a full burst's worth of lines has been queued, the packer posts the burst length to a small length queue. The writer stays idle until a length is posted. It then issues one address request for that many lines at the next line offset and streams the lines out as a single burst. Meanwhile the packer fills the following burst.

A run ends when end-of-stream arrives or when the output region of `CAP_LINES` lines is full. The writer then pulses a completion flag once the last burst has drained. A counter reports how many real items were stored, not counting padding. Each run begins at reset.

Top module: `stream_burst_writer`

## Requirements
- R1: After reset, in_ready is 1, mem_req, mem_wvalid and done are 0, and item_count is 0.
- R2: Items fill a line from the least significant end: the n-th item of a line (counting from 0) sits at bits [n*ITEM_W +: ITEM_W] of mem_wdata.
- R3: The line queue holds 2*BURST_LINES lines. If the memory never acknowledges an address request, the block accepts exactly 2*BURST_LINES*(LINE_W/ITEM_W) items and then holds in_ready low.
- R4: Every burst that is not the final one of a run carries mem_len equal to BURST_LINES. A request is raised only once all its lines are queued.
- R5: The first burst starts at BASE_ADDR. Each later burst starts at BASE_ADDR plus the number of lines already written, with addresses counted in lines.
- R6: After an address request is acknowledged, exactly mem_len data beats follow. mem_wlast is 1 on the last beat only. No address request is raised while data beats are offered.
- R7: An end-of-stream beat (in_eos=1 with in_valid; in_data ignored) that arrives while a line is partly filled emits that line with the empty slots set to zero. The final burst then carries the number of lines still pending, which is below BURST_LINES.
- R8: An end-of-stream beat that arrives with no lines pending, including on an empty stream, raises no address request, but done still pulses.
- R9: Once CAP_LINES lines have been packed, in_ready stays low, no further items are taken, and done pulses after the last of those lines is written.
- R10: done is high for exactly one cycle per run, after the final data beat. At that point item_count equals the number of items accepted.
- R11: While mem_req is high and not acknowledged, mem_addr and mem_len hold their values. While mem_wvalid is high and mem_wready is low, mem_wdata holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a new run |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | ITEM_W | Item value (ignored on end-of-stream beats) |
| in_eos | input | 1 | Beat is the end-of-stream marker, carries no item |
| mem_req | output | 1 | Address request valid |
| mem_req_ack | input | 1 | Memory accepts the address request |
| mem_addr | output | ADDR_W | Burst start address in lines |
| mem_len | output | clog2(BURST_LINES+1) | Burst length in lines |
| mem_wvalid | output | 1 | Write data beat valid |
| mem_wready | input | 1 | Memory accepts the data beat |
| mem_wdata | output | LINE_W | Line being written |
| mem_wlast | output | 1 | Final beat of the burst |
| done | output | 1 | One-cycle pulse when the run has been fully written |
| item_count | output | clog2(CAP_LINES*LINE_W/ITEM_W+1) | Items accepted and stored in this run |

## Verification
The bench targets the edges of the burst arithmetic. It sends an end-of-stream exactly on a burst boundary; a design that always flushed would issue a zero-length burst or never signal completion. It ends a stream mid-line; a design with stale slots would write old item bytes into the pad, and a wrong remainder would shorten or lengthen the last burst. It holds off address acknowledgement to show that the packer stops at exactly two bursts of queued lines, which would catch an undersized queue or an overflow. It also fills the output region to capacity to confirm that further items are refused and that completion still fires.

// File: rtl/bsw_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-stage burst stream writer.
package bsw_pkg;
    // Writer sequencing: wait for a length, present the address, stream lines, finished.
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_ADDR = 2'd1,
        WR_DATA = 2'd2,
        WR_FIN  = 2'd3
    } wr_state_e;
endpackage

// File: rtl/bsw_fifo.sv
`timescale 1ns/1ps
// bsw_fifo: synchronous first-in first-out queue with show-ahead read data.
// Assumes the producer never pushes while full and the consumer never pops
// while empty; simultaneous push and pop keep the fill level unchanged.
module bsw_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    fill;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign rd_data = store[rd_ptr];

    // Storage write; contents need no reset since fill gates every read.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= wr_data;
        end
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            end
            if (push && !pop) begin
                fill <= fill + CW'(1);
            end else if (pop && !push) begin
                fill <= fill - CW'(1);
            end
        end
    end

    // R3: the producer must respect the full flag.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("queue pushed while full");

    // R6: the consumer must respect the empty flag.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("queue popped while empty");
endmodule

// File: rtl/bsw_packer.sv
`timescale 1ns/1ps
// bsw_packer: stage one. Packs items into lines (slot 0 = least significant),
// pushes each complete line to the line queue and posts a {last, length}
// entry to the length queue after every BURST_LINES lines, at end-of-stream
// and when the output region is full. Assumes a run starts at reset.
module bsw_packer #(
    parameter int ITEM_W      = 8,
    parameter int LINE_W      = 32,
    parameter int BURST_LINES = 4,
    parameter int CAP_LINES   = 16,
    localparam int IPL        = LINE_W / ITEM_W,
    localparam int LEN_W      = $clog2(BURST_LINES + 1),
    localparam int NW         = $clog2(CAP_LINES * IPL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ITEM_W-1:0] in_data,
    input  logic              in_eos,
    input  logic              line_full,
    input  logic              cnt_full,
    output logic              line_push,
    output logic [LINE_W-1:0] line_data,
    output logic              cnt_push,
    output logic [LEN_W:0]    cnt_data,
    output logic [NW-1:0]     item_count
);
    localparam int SW = (IPL > 1) ? $clog2(IPL) : 1;
    localparam int TW = $clog2(CAP_LINES + 1);

    logic [SW-1:0]     slot_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] merged;
    logic [LEN_W-1:0]  burst_q;
    logic [LEN_W-1:0]  burst_after;
    logic [TW-1:0]     total_q;
    logic [TW-1:0]     total_after;
    logic              fin_q;
    logic              accept;
    logic              take_item;
    logic              take_eos;
    logic              line_done;
    logic              cap_hit;
    logic              burst_full;
    logic              cnt_last;

    // Accept only when both queues have room, so no push can overflow.
    assign in_ready  = !fin_q && !line_full && !cnt_full;
    assign accept    = in_valid && in_ready;
    assign take_item = accept && !in_eos;
    assign take_eos  = accept && in_eos;

    // Drop the incoming item into its slot of the line being built.
    always_comb begin
        merged = line_q;
        for (int s = 0; s < IPL; s++) begin
            if (slot_q == SW'(s)) begin
                merged[s*ITEM_W +: ITEM_W] = in_data;
            end
        end
    end

    // Line emission: a full line, or a partial line flushed at end-of-stream.
    assign line_done = take_item && (slot_q == SW'(IPL - 1));
    assign line_push = line_done || (take_eos && (slot_q != '0));
    assign line_data = take_eos ? line_q : merged;

    // Burst accounting for the line just emitted.
    assign burst_after = line_push ? burst_q + LEN_W'(1) : burst_q;
    assign total_after = line_push ? total_q + TW'(1) : total_q;
    assign cap_hit     = line_push && (total_after == TW'(CAP_LINES));
    assign burst_full  = line_push && (burst_after == LEN_W'(BURST_LINES));
    assign cnt_last    = cap_hit || take_eos;
    assign cnt_push    = burst_full || cnt_last;
    assign cnt_data    = {cnt_last, burst_after};

    assign item_count  = NW'(0) + item_q_w;

    logic [NW-1:0] item_q_w;

    // Slot position and partial line; cleared after every emitted line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            line_q <= '0;
        end else if (take_item) begin
            slot_q <= line_done ? '0 : slot_q + SW'(1);
            line_q <= line_done ? '0 : merged;
        end else if (take_eos) begin
            slot_q <= '0;
            line_q <= '0;
        end
    end

    // Lines in the open burst, lines in the run, run-finished flag, items taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q  <= '0;
            total_q  <= '0;
            fin_q    <= 1'b0;
            item_q_w <= '0;
        end else begin
            burst_q <= cnt_push ? '0 : burst_after;
            total_q <= total_after;
            if (cnt_last) begin
                fin_q <= 1'b1;
            end
            if (take_item) begin
                item_q_w <= item_q_w + NW'(1);
            end
        end
    end

    // R4: a posted length never exceeds a burst, and only the final one is short.
    p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_push |-> (cnt_data[LEN_W-1:0] <= LEN_W'(BURST_LINES)) &&
                     (cnt_data[LEN_W] || (cnt_data[LEN_W-1:0] == LEN_W'(BURST_LINES))))
        else $error("bad burst length posted");

    // R9: once the run has finished no further beat is taken.
    p_no_take_after_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_last) |-> !accept)
        else $error("beat accepted after the run ended");
endmodule

// File: rtl/bsw_writer.sv
`timescale 1ns/1ps
// bsw_writer: stage two. Waits for a {last, length} entry, issues one address
// request for that many lines at the running line offset, then streams the
// lines from the line queue. Pulses done after the final burst, or at once
// for a final entry of length zero. Assumes lines precede their length entry.
module bsw_writer #(
    parameter int LINE_W      = 32,
    parameter int BURST_LINES = 4,
    parameter int CAP_LINES   = 16,
    parameter int ADDR_W      = 16,
    parameter int BASE_ADDR   = 'h100,
    localparam int LEN_W      = $clog2(BURST_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_empty,
    input  logic [LEN_W:0]    cnt_data,
    output logic              cnt_pop,
    input  logic              line_empty,
    input  logic [LINE_W-1:0] line_data,
    output logic              line_pop,
    output logic              mem_req,
    input  logic              mem_req_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [LINE_W-1:0] mem_wdata,
    output logic              mem_wlast,
    output logic              done
);
    import bsw_pkg::*;

    localparam int OW = $clog2(CAP_LINES + 1);

    wr_state_e        state_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] left_q;
    logic             last_q;
    logic [OW-1:0]    off_q;
    logic             done_q;

    // Port drive from the current state.
    assign cnt_pop    = (state_q == WR_IDLE) && !cnt_empty;
    assign mem_req    = (state_q == WR_ADDR);
    assign mem_addr   = ADDR_W'(BASE_ADDR) + ADDR_W'(off_q);
    assign mem_len    = len_q;
    assign mem_wvalid = (state_q == WR_DATA) && !line_empty;
    assign mem_wdata  = line_data;
    assign mem_wlast  = (left_q == LEN_W'(1));
    assign line_pop   = mem_wvalid && mem_wready;
    assign done       = done_q;

    // Burst sequencing, line offset and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            len_q   <= '0;
            left_q  <= '0;
            last_q  <= 1'b0;
            off_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                WR_IDLE: begin
                    if (cnt_pop) begin
                        len_q  <= cnt_data[LEN_W-1:0];
                        left_q <= cnt_data[LEN_W-1:0];
                        last_q <= cnt_data[LEN_W];
                        if (cnt_data[LEN_W-1:0] != '0) begin
                            state_q <= WR_ADDR;
                        end else if (cnt_data[LEN_W]) begin
                            state_q <= WR_FIN;
                            done_q  <= 1'b1;
                        end
                    end
                end
                WR_ADDR: begin
                    if (mem_req_ack) begin
                        state_q <= WR_DATA;
                    end
                end
                WR_DATA: begin
                    if (line_pop) begin
                        off_q  <= off_q + OW'(1);
                        left_q <= left_q - LEN_W'(1);
                        if (left_q == LEN_W'(1)) begin
                            if (last_q) begin
                                state_q <= WR_FIN;
                                done_q  <= 1'b1;
                            end else begin
                                state_q <= WR_IDLE;
                            end
                        end
                    end
                end
                default: state_q <= WR_FIN;
            endcase
        end
    end

    // R11: an unacknowledged request keeps its address and length.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_req_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_len))
        else $error("request dropped or changed before acknowledge");

    // R11: an unaccepted data beat keeps its payload.
    p_wdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> mem_wvalid && $stable(mem_wdata))
        else $error("data beat dropped or changed before accept");

    // R10: completion is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

    // R6: address and data phases never overlap.
    p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> !mem_req)
        else $error("request raised during data phase");
endmodule

// File: rtl/stream_burst_writer.sv
`timescale 1ns/1ps
// stream_burst_writer: top level. Packer and writer run concurrently,
// decoupled by a line queue of two bursts and a small length queue.
// Assumes LINE_W is a multiple of ITEM_W and one run per reset.
module stream_burst_writer #(
    parameter int ITEM_W      = 8,
    parameter int LINE_W      = 32,
    parameter int BURST_LINES = 4,
    parameter int CAP_LINES   = 16,
    parameter int ADDR_W      = 16,
    parameter int BASE_ADDR   = 'h100,
    parameter int LEN_DEPTH   = 2
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                in_valid,
    output logic                                                in_ready,
    input  logic [ITEM_W-1:0]                                   in_data,
    input  logic                                                in_eos,
    output logic                                                mem_req,
    input  logic                                                mem_req_ack,
    output logic [ADDR_W-1:0]                                   mem_addr,
    output logic [$clog2(BURST_LINES+1)-1:0]                    mem_len,
    output logic                                                mem_wvalid,
    input  logic                                                mem_wready,
    output logic [LINE_W-1:0]                                   mem_wdata,
    output logic                                                mem_wlast,
    output logic                                                done,
    output logic [$clog2(CAP_LINES*(LINE_W/ITEM_W)+1)-1:0]      item_count
);
    localparam int LEN_W      = $clog2(BURST_LINES + 1);
    localparam int LINE_DEPTH = 2 * BURST_LINES;

    logic              line_push, line_pop, line_full, line_empty;
    logic [LINE_W-1:0] line_wr, line_rd;
    logic              cnt_push, cnt_pop, cnt_full, cnt_empty;
    logic [LEN_W:0]    cnt_wr, cnt_rd;

    bsw_packer #(
        .ITEM_W(ITEM_W), .LINE_W(LINE_W),
        .BURST_LINES(BURST_LINES), .CAP_LINES(CAP_LINES)
    ) u_packer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_eos(in_eos),
        .line_full(line_full), .cnt_full(cnt_full),
        .line_push(line_push), .line_data(line_wr),
        .cnt_push(cnt_push), .cnt_data(cnt_wr),
        .item_count(item_count)
    );

    bsw_fifo #(.WIDTH(LINE_W), .DEPTH(LINE_DEPTH)) u_line_q (
        .clk(clk), .rst_n(rst_n),
        .push(line_push), .wr_data(line_wr),
        .pop(line_pop), .rd_data(line_rd),
        .full(line_full), .empty(line_empty)
    );

    bsw_fifo #(.WIDTH(LEN_W + 1), .DEPTH(LEN_DEPTH)) u_len_q (
        .clk(clk), .rst_n(rst_n),
        .push(cnt_push), .wr_data(cnt_wr),
        .pop(cnt_pop), .rd_data(cnt_rd),
        .full(cnt_full), .empty(cnt_empty)
    );

    bsw_writer #(
        .LINE_W(LINE_W), .BURST_LINES(BURST_LINES), .CAP_LINES(CAP_LINES),
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_writer (
        .clk(clk), .rst_n(rst_n),
        .cnt_empty(cnt_empty), .cnt_data(cnt_rd), .cnt_pop(cnt_pop),
        .line_empty(line_empty), .line_data(line_rd), .line_pop(line_pop),
        .mem_req(mem_req), .mem_req_ack(mem_req_ack),
        .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_wdata(mem_wdata), .mem_wlast(mem_wlast),
        .done(done)
    );
endmodule

// File: tb/sim_stream_burst_writer.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results
// against a small memory model that records bursts and line contents.
module sim_stream_burst_writer;
    localparam int BASE = 'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_eos = 1'b0;
    logic        mem_req;
    logic        mem_req_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [2:0]  mem_len;
    logic        mem_wvalid;
    logic        mem_wready = 1'b0;
    logic [31:0] mem_wdata;
    logic        mem_wlast;
    logic        done;
    logic [6:0]  item_count;

    int total = 0;
    int bad   = 0;

    // Memory model state.
    bit          ack_hold;
    int          wr_mode;
    bit          wr_phase;
    logic [31:0] img [0:63];
    int          nburst;
    int          b_addr [0:15];
    int          b_len  [0:15];
    int          cur_idx, cur_len, beat_i, nbeats, wlast_err;
    int          done_cnt, done_wide;
    bit          done_prev;

    stream_burst_writer #(
        .ITEM_W(8), .LINE_W(32), .BURST_LINES(4), .CAP_LINES(16),
        .ADDR_W(16), .BASE_ADDR(BASE), .LEN_DEPTH(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eos(in_eos),
        .mem_req(mem_req), .mem_req_ack(mem_req_ack),
        .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_wdata(mem_wdata), .mem_wlast(mem_wlast),
        .done(done), .item_count(item_count)
    );

    always #4 clk = ~clk;

    // Memory responder: drives handshakes and records transfers at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ack = 1'b0;
            mem_wready  = 1'b0;
        end else begin
            mem_req_ack = mem_req && !ack_hold;
            if (wr_mode == 1) begin
                wr_phase   = !wr_phase;
                mem_wready = wr_phase;
            end else begin
                mem_wready = 1'b1;
            end
            if (mem_req && mem_req_ack) begin
                if (nburst < 16) begin
                    b_addr[nburst] = int'(mem_addr);
                    b_len[nburst]  = int'(mem_len);
                end
                nburst++;
                cur_idx = int'(mem_addr) - BASE;
                cur_len = int'(mem_len);
                beat_i  = 0;
            end
            if (mem_wvalid && mem_wready) begin
                if (cur_idx + beat_i >= 0 && cur_idx + beat_i < 64) begin
                    img[cur_idx + beat_i] = mem_wdata;
                end
                if (mem_wlast !== (beat_i == cur_len - 1)) wlast_err++;
                beat_i++;
                nbeats++;
            end
            if (done) begin
                done_cnt++;
                if (done_prev) done_wide++;
            end
            done_prev = done;
        end
    end

    task automatic checkeq(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_line(input int base, input int n, input int j);
        logic [31:0] r = '0;
        for (int s = 0; s < 4; s++) begin
            if (4 * j + s < n) r[s*8 +: 8] = 8'(base + 4 * j + s);
        end
        return r;
    endfunction

    task automatic line_mismatch(input int base, input int n, input int nlines, output int mism);
        mism = 0;
        for (int j = 0; j < nlines; j++) begin
            if (img[j] !== exp_line(base, n, j)) mism++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_eos   = 1'b0;
        in_data  = '0;
        ack_hold = 1'b0;
        wr_mode  = 0;
        wr_phase = 1'b0;
        for (int i = 0; i < 64; i++) img[i] = '0;
        for (int i = 0; i < 16; i++) begin b_addr[i] = 0; b_len[i] = 0; end
        nburst = 0; nbeats = 0; wlast_err = 0; beat_i = 0; cur_idx = 0; cur_len = 0;
        done_cnt = 0; done_wide = 0; done_prev = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one beat from a falling edge; ok reports whether it was taken.
    task automatic send(input logic [7:0] d, input bit eos, input int maxwait, output bit ok);
        in_valid = 1'b1;
        in_data  = d;
        in_eos   = eos;
        ok       = 1'b0;
        for (int w = 0; w < maxwait; w++) begin
            if (in_ready) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        if (ok) @(negedge clk);
        in_valid = 1'b0;
        in_eos   = 1'b0;
    endtask

    task automatic stream(input int base, input int first, input int n);
        bit ok;
        for (int k = first; k < n; k++) send(8'(base + k), 1'b0, 1000, ok);
    endtask

    task automatic wait_done();
        for (int w = 0; w < 3000 && done_cnt == 0; w++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        checkeq("R1 in_ready after reset", in_ready, 1);
        checkeq("R1 mem_req after reset", mem_req, 0);
        checkeq("R1 mem_wvalid after reset", mem_wvalid, 0);
        checkeq("R1 done after reset", done, 0);
        checkeq("R1 item_count after reset", item_count, 0);
    endtask

    task automatic t_full_bursts();
        bit ok; int mism;
        do_reset();
        stream('h10, 0, 32);
        send(8'h00, 1'b1, 1000, ok);
        wait_done();
        line_mismatch('h10, 32, 8, mism);
        checkeq("R2 packed line contents", mism, 0);
        checkeq("R4 burst count", nburst, 2);
        checkeq("R4 first burst length", b_len[0], 4);
        checkeq("R4 second burst length", b_len[1], 4);
        checkeq("R5 first burst address", b_addr[0], BASE);
        checkeq("R5 second burst address", b_addr[1], BASE + 4);
        checkeq("R6 data beats", nbeats, 8);
        checkeq("R6 wlast placement errors", wlast_err, 0);
        checkeq("R8 no extra burst at boundary eos", nburst, 2);
        checkeq("R10 done pulses", done_cnt, 1);
        checkeq("R10 done width", done_wide, 0);
        checkeq("R10 item_count", item_count, 32);
    endtask

    task automatic t_partial();
        bit ok; int mism;
        do_reset();
        wr_mode = 1;
        stream('h40, 0, 22);
        send(8'hEE, 1'b1, 1000, ok);
        wait_done();
        line_mismatch('h40, 22, 6, mism);
        checkeq("R7 line contents with pad", mism, 0);
        checkeq("R7 padded line", img[5], exp_line('h40, 22, 5));
        checkeq("R7 burst count", nburst, 2);
        checkeq("R7 final burst length", b_len[1], 2);
        checkeq("R5 final burst address", b_addr[1], BASE + 4);
        checkeq("R6 wlast with slow ready", wlast_err, 0);
        checkeq("R10 item_count partial", item_count, 22);
        checkeq("R10 done partial", done_cnt, 1);
    endtask

    task automatic t_empty();
        bit ok;
        do_reset();
        send(8'h55, 1'b1, 1000, ok);
        wait_done();
        checkeq("R8 no burst on empty stream", nburst, 0);
        checkeq("R8 done on empty stream", done_cnt, 1);
        checkeq("R8 item_count empty", item_count, 0);
    endtask

    task automatic t_backpressure();
        bit ok; int acc; int mism; int a0;
        do_reset();
        ack_hold = 1'b1;
        acc = 0;
        for (int k = 0; k < 40; k++) begin
            send(8'(k), 1'b0, 30, ok);
            if (!ok) break;
            acc++;
        end
        checkeq("R3 items taken while writer stalled", acc, 32);
        checkeq("R3 in_ready low when queue full", in_ready, 0);
        a0 = int'(mem_addr);
        checkeq("R11 request held", mem_req, 1);
        repeat (10) @(negedge clk);
        checkeq("R11 request still held", mem_req, 1);
        checkeq("R11 address stable", int'(mem_addr), a0);
        checkeq("R11 length stable", mem_len, 4);
        ack_hold = 1'b0;
        stream(0, acc, 40);
        send(8'h00, 1'b1, 1000, ok);
        wait_done();
        line_mismatch(0, 40, 10, mism);
        checkeq("R3 contents after stall", mism, 0);
        checkeq("R4 bursts after stall", nburst, 3);
        checkeq("R7 last length after stall", b_len[2], 2);
        checkeq("R5 third burst address", b_addr[2], BASE + 8);
        checkeq("R10 item_count after stall", item_count, 40);
    endtask

    task automatic t_capacity();
        bit ok; int extra; int mism;
        do_reset();
        stream('h80, 0, 64);
        extra = 0;
        for (int k = 0; k < 6; k++) begin
            send(8'hAA, 1'b0, 30, ok);
            if (ok) extra++;
        end
        wait_done();
        checkeq("R9 items refused past capacity", extra, 0);
        checkeq("R9 in_ready stays low", in_ready, 0);
        checkeq("R9 burst count at capacity", nburst, 4);
        checkeq("R9 last burst address", b_addr[3], BASE + 12);
        line_mismatch('h80, 64, 16, mism);
        checkeq("R9 contents at capacity", mism, 0);
        checkeq("R9 done at capacity", done_cnt, 1);
        checkeq("R10 item_count at capacity", item_count, 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_bursts();
        t_partial();
        t_empty();
        t_backpressure();
        t_capacity();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule